// File: doc/BRIEF.md
# High-Radix Montgomery Modular Multiplier

This block performs one Montgomery modular multiplication with radix-2^K digits. Given an odd modulus `m`, a multiplicand `A` and a multiplier `B`, it returns `S` with S ≡ A·B·2^(−K·N) (mod m) and −m < S < m. Because the result stays in the same open interval as the inputs, it can be fed straight back as the next operand of a modular exponentiation chain without a correction step.

The multiplier is supplied as N signed digits. The caller also supplies the low K bits of the constant m' = −m⁻¹ mod 2^K. After a start pulse the block runs N+1 iterations, one per clock. Each iteration takes a quotient digit from the low K bits of the accumulator, adds that multiple of `m`, shifts right by K bits exactly, and adds the current multiplier digit times `A`. A one-cycle done pulse marks the result.

Top module: `mont_mul_hr`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0.
- R2: A `start_i` sampled high while idle begins an operation. `done_o` is high for exactly one cycle, N+1 clock edges after the accepting edge, and `busy_o` is high in between.
- R3: The result `s_o` equals the value produced by the N+1 step recurrence. S starts at 0. Each step forms q = ((S mod 2^K)·m') mod 2^K, read as a K-bit two's-complement value in [−2^(K−1), 2^(K−1)). Then S := (S + q·m)/2^K + b_i·A, with b_N = 0. The result satisfies S·2^(K·N) ≡ A·B (mod m).
- R4: For odd m < 2^(K·N−2) and −m < A, B < m, the result satisfies −m < `s_o` < m and fits the W-bit signed output.
- R5: In every step, S + q·m is divisible by 2^K.
- R6: A `start_i` pulse while busy is ignored: the running operation keeps its operands and its done timing, and no extra result is produced.
- R7: `b_digits_i` packs N digits of K+1 bits, each in two's complement. Digit i sits at bits [i·(K+1) +: K+1] and is consumed in iteration i, least significant first. Digit values up to ±(2^K−1) are accepted.
- R8: While idle, `s_o` holds its last result regardless of input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| a_i | input | W | Multiplicand A, signed |
| b_digits_i | input | N*(K+1) | Multiplier digits, signed, packed |
| m_i | input | W | Odd modulus |
| mprime_i | input | K | Low K bits of −m⁻¹ mod 2^K |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result strobe |
| s_o | output | W | Result S, signed |

## Verification
The assertions check, on every cycle, the exactness of the divide-by-2^K step, the single-cycle done pulse and its position after the final iteration, the bound and width of the result, operand stability while running, and output hold while idle. The numeric correctness of the result can only be shown by the scenarios. These compare each result against an independent model of the recurrence and a congruence test, over random moduli, extreme operands, zero operands and maximum-magnitude digits. The scenarios also show that a start during an operation produces no extra result.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} mm_state_e;
endpackage

// File: rtl/mmul_qdigit.sv
module mmul_qdigit #(
  parameter int K = 4
) (
  input  logic [K-1:0]        s_lo_i,
  input  logic [K-1:0]        mprime_i,
  output logic signed [K-1:0] q_o
);
  logic [K-1:0] prod;
  // K-bit product read as two's complement gives the symmetric remainder
  assign prod = s_lo_i * mprime_i;
  assign q_o  = $signed(prod);
endmodule

// File: rtl/mmul_step.sv
module mmul_step #(
  parameter int K  = 4,
  parameter int W  = 32,
  parameter int AW = 38
) (
  input  logic signed [AW-1:0] acc_i,
  input  logic signed [K-1:0]  q_i,
  input  logic [W-1:0]         m_i,
  input  logic signed [W-1:0]  a_i,
  input  logic signed [K:0]    b_i,
  output logic signed [AW-1:0] nxt_o
);
  logic signed [AW-1:0] q_x, m_x, a_x, b_x, sum;

  assign q_x   = AW'(q_i);
  assign m_x   = AW'($signed({1'b0, m_i}));
  assign a_x   = AW'(a_i);
  assign b_x   = AW'(b_i);
  assign sum   = acc_i + q_x * m_x;
  assign nxt_o = (sum >>> K) + b_x * a_x;
endmodule

// File: rtl/mmul_ctrl.sv
module mmul_ctrl
  import mmul_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          load_o,
  output logic          run_o,
  output logic          last_o,
  output logic [CW-1:0] idx_o,
  output logic          done_o
);
  mm_state_e state;

  assign load_o = (state == ST_IDLE) && start_i;
  assign run_o  = (state == ST_RUN);
  assign last_o = run_o && (idx_o == CW'(N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      idx_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        state <= ST_RUN;
        idx_o <= '0;
      end else if (run_o) begin
        if (last_o) begin
          state  <= ST_IDLE;
          done_o <= 1'b1;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_finish_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (done_o && !run_o));
  p_no_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !last_o) |=> run_o);
endmodule

// File: rtl/mont_mul_hr.sv
module mont_mul_hr #(
  parameter int K = 4,
  parameter int N = 8,
  localparam int W  = K * N,
  localparam int AW = K * N + K + 2,
  localparam int DW = K + 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic signed [W-1:0] a_i,
  input  logic [N*DW-1:0]     b_digits_i,
  input  logic [W-1:0]        m_i,
  input  logic [K-1:0]        mprime_i,
  output logic                busy_o,
  output logic                done_o,
  output logic signed [W-1:0] s_o
);
  logic                 load, run, last;
  logic [CW-1:0]        idx;
  logic signed [W-1:0]  a_r;
  logic [N*DW-1:0]      b_r;
  logic [W-1:0]         m_r;
  logic [K-1:0]         mp_r;
  logic signed [AW-1:0] acc, nxt;
  logic signed [K-1:0]  q;
  logic signed [DW-1:0] dig [N+1];
  logic signed [DW-1:0] b_sel;

  mmul_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .run_o(run), .last_o(last), .idx_o(idx), .done_o(done_o)
  );

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_dig
      assign dig[gi] = $signed(b_r[gi*DW +: DW]);
    end
  endgenerate
  assign dig[N] = '0;  // top digit is implicitly zero
  assign b_sel  = dig[idx];

  mmul_qdigit #(.K(K)) u_q (
    .s_lo_i(acc[K-1:0]), .mprime_i(mp_r), .q_o(q)
  );

  mmul_step #(.K(K), .W(W), .AW(AW)) u_step (
    .acc_i(acc), .q_i(q), .m_i(m_r), .a_i(a_r), .b_i(b_sel), .nxt_o(nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_r  <= '0;
      b_r  <= '0;
      m_r  <= '0;
      mp_r <= '0;
      acc  <= '0;
      s_o  <= '0;
    end else begin
      if (load) begin
        a_r  <= a_i;
        b_r  <= b_digits_i;
        m_r  <= m_i;
        mp_r <= mprime_i;
        acc  <= '0;
      end else if (run) begin
        acc <= nxt;
        if (last) s_o <= nxt[W-1:0];
      end
    end
  end

  assign busy_o = run;

  p_exact_div_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (K'(acc[K-1:0] + K'(q) * m_r[K-1:0]) == '0));
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |-> ((nxt[AW-1:W-1] == '0) || (nxt[AW-1:W-1] == '1)));
  p_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (($signed({s_o[W-1], s_o}) < $signed({1'b0, m_r})) &&
                ($signed({s_o[W-1], s_o}) > -$signed({1'b0, m_r}))));
  p_opnd_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> ($stable(a_r) && $stable(b_r) && $stable(m_r) && $stable(mp_r)));
  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(s_o));
endmodule

// File: tb/mont_mul_hr_test.sv
module mont_mul_hr_test;
  localparam int K  = 4;
  localparam int N  = 8;
  localparam int W  = K * N;
  localparam int DW = K + 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start = 1'b0;
  logic signed [W-1:0] a_in = '0;
  logic [N*DW-1:0]     b_in = '0;
  logic [W-1:0]        m_in = '0;
  logic [K-1:0]        mp_in = '0;
  logic                busy, done;
  logic signed [W-1:0] s_out;

  int checks = 0, bad = 0, ndone = 0;
  longint cyc = 0;
  bit prev_done = 1'b0;

  typedef struct {
    longint s_exp;
    longint a;
    longint b;
    longint m;
    longint c0;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  mont_mul_hr #(.K(K), .N(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a_in),
    .b_digits_i(b_in), .m_i(m_in), .mprime_i(mp_in),
    .busy_o(busy), .done_o(done), .s_o(s_out)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  function automatic longint model(input longint a, input longint m, input int mp,
                                   input int d[N]);
    longint s = 0;
    for (int i = 0; i <= N; i++) begin
      longint p, q, bi;
      p  = ((s & 15) * mp) & 15;
      q  = (p >= 8) ? p - 16 : p;
      bi = (i < N) ? d[i] : 0;
      s  = ((s + q * m) >>> K) + bi * a;
    end
    return s;
  endfunction

  // monitor: pops expected items when a result appears
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R2 done longer than one cycle", 1, 0);
      if (done) begin
        ndone++;
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected result", s_out, 0);
        end else begin
          exp_t e;
          longint s, diff;
          e = sb.pop_front();
          s = s_out;
          chk(s == e.s_exp, "R3 R7 result value", s, e.s_exp);
          diff = (s <<< W) - e.a * e.b;
          chk(diff % e.m == 0, "R3 congruence residue", diff % e.m, 0);
          chk(s < e.m && s > -e.m, "R4 bound", s, e.m);
          chk(cyc - e.c0 == N + 2, "R2 latency", cyc - e.c0, N + 2);
        end
      end
      prev_done <= done;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", cyc, 100000);
        finish_run();
      end
    end
  end

  function automatic int calc_mp(input longint m);
    int r = 0;
    for (int x = 0; x < 16; x++) if (((m * x) & 15) == 15) r = x;
    return r;
  endfunction

  task automatic run_op(input longint a, input longint m, input int d[N], input bit poke);
    exp_t e;
    longint b = 0;
    int mp, n0;
    for (int i = N - 1; i >= 0; i--) b = b * 16 + d[i];
    mp = calc_mp(m);
    @(negedge clk);
    a_in  = W'(a);
    m_in  = W'(m);
    mp_in = K'(mp);
    for (int i = 0; i < N; i++) b_in[i*DW +: DW] = DW'(d[i]);
    start = 1'b1;
    e.s_exp = model(a, m, mp, d);
    e.a = a; e.b = b; e.m = m; e.c0 = cyc;
    sb.push_back(e);
    n0 = ndone;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    if (poke) begin
      // R6: start with other operands while busy
      @(negedge clk);
      a_in = '0; m_in = 32'd3; b_in = '1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (ndone == n0) @(negedge clk);
    // R8: change inputs while idle, output must hold
    a_in = ~a_in; b_in = ~b_in;
    repeat (3) @(negedge clk);
    chk(s_out == W'(e.s_exp), "R8 hold while idle", s_out, e.s_exp);
    chk(ndone == n0 + 1, "R6 single result", ndone, n0 + 1);
  endtask

  task automatic recode(input longint b, output int d[N]);
    for (int i = 0; i < N; i++) begin
      longint r;
      r = b & 15;
      if (r >= 8) r = r - 16;
      d[i] = int'(r);
      b = (b - r) >>> 4;
    end
  endtask

  initial begin
    int d[N];
    longint m, a, b;
    #20;
    chk(busy == 1'b0, "R1 busy at reset", busy, 0);
    chk(done == 1'b0, "R1 done at reset", done, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // zero operands
    m = 1000003;
    recode(12345, d);
    run_op(0, m, d, 1'b0);
    recode(0, d);
    run_op(-999, m, d, 1'b0);

    // extreme operands near the bound
    m = (64'd1 << 30) - 1;
    recode(-(m - 1), d);
    run_op(m - 1, m, d, 1'b0);
    recode(m - 1, d);
    run_op(-(m - 1), m, d, 1'b0);

    // R7: maximum-magnitude digits
    for (int i = 0; i < N; i++) d[i] = 0;
    d[0] = 15; d[1] = -15; d[3] = 15;
    run_op(-123457, 64'd900000001, d, 1'b0);

    // R6: start while busy
    recode(777777, d);
    run_op(31415, 64'd2000001, d, 1'b1);

    // random moduli and operands
    for (int t = 0; t < 12; t++) begin
      if (t % 3 == 0) m = longint'($urandom % 1000) * 2 + 3;
      else m = longint'($urandom & 32'h3FFF_FFFF) | 1 | (64'd1 << 28);
      a = longint'($urandom % (2 * m - 1)) - (m - 1);
      b = longint'($urandom % (2 * m - 1)) - (m - 1);
      recode(b, d);
      run_op(a, m, d, t == 5);
    end

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2 all results seen", sb.size(), 0);
    finish_run();
  end
endmodule